// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block runs one DRAM bank through its three access phases: opening a row, accessing a column, and precharging the bit lines. A client hands it read or write requests carrying a row and a column address. The block issues one-cycle command strobes toward the bank. It presents the row and then the column on one shared address bus. It waits out a programmed number of cycles after each phase before starting the next one.

The block keeps a row open after it is used. A later request to the same row goes straight to the column phase, so repeated accesses within one row run at burst speed. A request to any other row first precharges the open row, which writes the row's latched contents back. The block then activates the new row and performs the column access. Read data is taken from the bank a fixed column latency after the read strobe and handed back as a one-cycle response.

The three phase delays are parameters, counted in clock cycles. A setting of about 15 to 20 ns suits most parts. The data width (`DQ_W`) is set at elaboration to 4, 8, 16 or 32 bits.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1, all four strobes and `rsp_valid` are 0, and `bank_addr` is 0. No row counts as open, so the first request begins with an activate and not with a precharge.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from that edge while any phase delay is still running. It returns to 1 in the cycle after the request's column delay expires.
- R3: Request to a closed bank: `bank_act` is asserted in the cycle after acceptance. `bank_rd` or `bank_wr` follows exactly `T_ACT` cycles after `bank_act`.
- R4: Request to the open row (hit): the column strobe is asserted in the cycle after acceptance, and neither `bank_pre` nor `bank_act` is issued.
- R5: Request to a row other than the open one (miss): `bank_pre` comes first. `bank_act` follows `T_PRE` cycles later, and the column strobe follows `T_ACT` cycles after that. An activate never reaches a bank that still has a row open.
- R6: Read: `rsp_valid` is high for exactly one cycle, `T_COL` cycles after `bank_rd`. `rsp_data` equals the `bank_rdata` value sampled at the edge that ends that interval. The bank must present its data by then, so `T_COL` must be at least 2.
- R7: Write: `bank_wr` is asserted with `req_wdata` on `bank_wdata`. No response is produced. The written value persists through a later precharge and reactivation of the row.
- R8: Two column strobes are never closer together than `T_COL` cycles.
- R9: At most one of `bank_act`, `bank_rd`, `bank_wr` and `bank_pre` is high in any cycle.
- R10: `bank_addr` carries the row (zero-extended) in an activate cycle and the column (zero-extended) in a column cycle. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_wdata | input | DQ_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | DQ_W | Read data |
| bank_act | output | 1 | Row activate strobe |
| bank_rd | output | 1 | Column read strobe |
| bank_wr | output | 1 | Column write strobe |
| bank_pre | output | 1 | Precharge strobe |
| bank_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| bank_wdata | output | DQ_W | Data for a column write |
| bank_rdata | input | DQ_W | Data returned by the bank |

## Verification
Every result is due a fixed number of edges after the accepting edge, where n counts from the first falling edge after that edge:

| Request type | Precharge | Activate | Column | Response and ready |
|---|---|---|---|---|
| Hit | none | none | n = 0 | n = T_COL |
| Closed bank | none | n = 0 | n = T_ACT | n = T_ACT + T_COL |
| Miss | n = 0 | n = T_PRE | n = T_PRE + T_ACT | n = T_PRE + T_ACT + T_COL |

The bench predicts this schedule for each request from the request type in its vector table. At every falling edge from n = 0 to the end it compares the strobes, the address bus, `req_ready` and `rsp_valid` with the predicted values.

A behavioural bank model holds a row latch and writes it back only on precharge. It flags any activate that reaches an open bank, so a skipped precharge shows up as lost data as well as a wrong strobe.

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int DQ_W  = 16,
  parameter int T_ACT = 3,
  parameter int T_COL = 3,
  parameter int T_PRE = 3,
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rsp_valid,
  output logic [DQ_W-1:0]   rsp_data,
  output logic              bank_act,
  output logic              bank_rd,
  output logic              bank_wr,
  output logic              bank_pre,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DQ_W-1:0]   bank_wdata,
  input  logic [DQ_W-1:0]   bank_rdata
);

  localparam int TMAX = (T_ACT > T_COL) ? ((T_ACT > T_PRE) ? T_ACT : T_PRE)
                                        : ((T_COL > T_PRE) ? T_COL : T_PRE);
  localparam int TW = (TMAX < 2) ? 1 : $clog2(TMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_ACT, S_COL} phase_t;

  phase_t            st;
  logic [TW-1:0]     tmr;
  logic              row_open;
  logic [ROW_W-1:0]  open_row;
  logic              p_write;
  logic [ROW_W-1:0]  p_row;
  logic [COL_W-1:0]  p_col;
  logic [DQ_W-1:0]   p_wdata;

  wire accept   = req_valid && req_ready;
  wire row_hit  = row_open && (req_row == open_row);
  wire tmr_done = (tmr == '0);

  assign req_ready = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tmr        <= '0;
      row_open   <= 1'b0;
      open_row   <= '0;
      p_write    <= 1'b0;
      p_row      <= '0;
      p_col      <= '0;
      p_wdata    <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      bank_act   <= 1'b0;
      bank_rd    <= 1'b0;
      bank_wr    <= 1'b0;
      bank_pre   <= 1'b0;
      bank_addr  <= '0;
      bank_wdata <= '0;
    end else begin
      bank_act  <= 1'b0;
      bank_rd   <= 1'b0;
      bank_wr   <= 1'b0;
      bank_pre  <= 1'b0;
      bank_addr <= '0;
      rsp_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          p_write <= req_write;
          p_row   <= req_row;
          p_col   <= req_col;
          p_wdata <= req_wdata;
          if (row_hit) begin
            bank_rd    <= !req_write;
            bank_wr    <= req_write;
            bank_addr  <= ADDR_W'(req_col);
            bank_wdata <= req_wdata;
            tmr        <= TW'(T_COL - 1);
            st         <= S_COL;
          end else if (row_open) begin
            bank_pre <= 1'b1;
            row_open <= 1'b0;
            tmr      <= TW'(T_PRE - 1);
            st       <= S_PRE;
          end else begin
            bank_act  <= 1'b1;
            bank_addr <= ADDR_W'(req_row);
            row_open  <= 1'b1;
            open_row  <= req_row;
            tmr       <= TW'(T_ACT - 1);
            st        <= S_ACT;
          end
        end
        S_PRE: if (tmr_done) begin
          bank_act  <= 1'b1;
          bank_addr <= ADDR_W'(p_row);
          row_open  <= 1'b1;
          open_row  <= p_row;
          tmr       <= TW'(T_ACT - 1);
          st        <= S_ACT;
        end else tmr <= tmr - 1'b1;
        S_ACT: if (tmr_done) begin
          bank_rd    <= !p_write;
          bank_wr    <= p_write;
          bank_addr  <= ADDR_W'(p_col);
          bank_wdata <= p_wdata;
          tmr        <= TW'(T_COL - 1);
          st         <= S_COL;
        end else tmr <= tmr - 1'b1;
        S_COL: if (tmr_done) begin
          if (!p_write) begin
            rsp_valid <= 1'b1;
            rsp_data  <= bank_rdata;
          end
          st <= S_IDLE;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_bank_seq_chk.sv
module dram_bank_seq_chk #(
  parameter int T_ACT = 3,
  parameter int T_COL = 3,
  parameter int T_PRE = 3
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic bank_act,
  input logic bank_rd,
  input logic bank_wr,
  input logic bank_pre
);

  localparam logic [7:0] GA = 8'(T_ACT);
  localparam logic [7:0] GC = 8'(T_COL);
  localparam logic [7:0] GP = 8'(T_PRE);

  logic [7:0] since_act, since_rd, since_col, since_pre;
  wire any_cmd = bank_act | bank_rd | bank_wr | bank_pre;
  wire col_cmd = bank_rd | bank_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 8'hFF;
      since_rd  <= 8'hFF;
      since_col <= 8'hFF;
      since_pre <= 8'hFF;
    end else begin
      since_act <= bank_act ? 8'd1 : (since_act == 8'hFF ? since_act : since_act + 8'd1);
      since_rd  <= bank_rd  ? 8'd1 : (since_rd  == 8'hFF ? since_rd  : since_rd  + 8'd1);
      since_col <= col_cmd  ? 8'd1 : (since_col == 8'hFF ? since_col : since_col + 8'd1);
      since_pre <= bank_pre ? 8'd1 : (since_pre == 8'hFF ? since_pre : since_pre + 8'd1);
    end
  end

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bank_act, bank_rd, bank_wr, bank_pre}) <= 1);

  a_r2_busy_during_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |-> !req_ready);

  a_r3_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd |-> since_act >= GA);

  a_r5_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    bank_act |-> since_pre >= GP);

  a_r8_col_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd |-> since_col >= GC);

  a_r6_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> since_rd == GC);

endmodule

bind dram_bank_seq dram_bank_seq_chk #(.T_ACT(T_ACT), .T_COL(T_COL), .T_PRE(T_PRE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bank_act(bank_act), .bank_rd(bank_rd), .bank_wr(bank_wr), .bank_pre(bank_pre)
);

// File: tb/dram_bank_seq_test.sv
module dram_bank_seq_test;
  localparam int RW = 4, CW = 3, DW = 8, TA = 3, TC = 2, TP = 4;
  localparam int AW = (RW > CW) ? RW : CW;
  localparam int NV = 13;

  // fields: kind(0 hit,1 closed,2 miss) write row col data
  localparam logic [17:0] VEC [0:NV-1] = '{
    {2'd1, 1'b1, 4'd5,  3'd2, 8'hA5},
    {2'd0, 1'b1, 4'd5,  3'd7, 8'h3C},
    {2'd0, 1'b0, 4'd5,  3'd2, 8'hA5},
    {2'd2, 1'b1, 4'd9,  3'd2, 8'h77},
    {2'd0, 1'b0, 4'd9,  3'd2, 8'h77},
    {2'd2, 1'b0, 4'd5,  3'd7, 8'h3C},
    {2'd0, 1'b0, 4'd5,  3'd2, 8'hA5},
    {2'd2, 1'b1, 4'd0,  3'd0, 8'h11},
    {2'd2, 1'b0, 4'd15, 3'd7, 8'h7F},
    {2'd2, 1'b0, 4'd0,  3'd0, 8'h11},
    {2'd0, 1'b1, 4'd0,  3'd0, 8'h22},
    {2'd0, 1'b0, 4'd0,  3'd0, 8'h22},
    {2'd2, 1'b0, 4'd9,  3'd3, 8'h4B}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, bank_act, bank_rd, bank_wr, bank_pre;
  logic [DW-1:0] rsp_data, bank_wdata, bank_rdata;
  logic [AW-1:0] bank_addr;

  int checks = 0, fails = 0, model_errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_bank_seq #(.ROW_W(RW), .COL_W(CW), .DQ_W(DW), .T_ACT(TA), .T_COL(TC), .T_PRE(TP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bank_act(bank_act), .bank_rd(bank_rd),
    .bank_wr(bank_wr), .bank_pre(bank_pre), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata));

  // behavioural bank: row latch written back only on precharge
  logic [DW-1:0] arr [0:(1<<RW)-1][0:(1<<CW)-1];
  logic [DW-1:0] lat [0:(1<<CW)-1];
  logic m_open = 1'b0;
  logic [RW-1:0] m_row = '0;
  logic [DW-1:0] m_rdata = '0;
  assign bank_rdata = m_rdata;

  initial
    for (int r = 0; r < (1<<RW); r++)
      for (int c = 0; c < (1<<CW); c++) arr[r][c] = DW'((r << CW) | c);

  always @(posedge clk) begin
    if (!rst_n) begin
      if (m_open) for (int c = 0; c < (1<<CW); c++) arr[m_row][c] = lat[c];
      m_open = 1'b0;
    end else begin
      if (bank_pre) begin
        if (!m_open) begin model_errs++; $display("FAIL R5 model: precharge with no open row act=0 exp=1"); end
        for (int c = 0; c < (1<<CW); c++) arr[m_row][c] = lat[c];
        m_open = 1'b0;
      end
      if (bank_act) begin
        if (m_open) begin model_errs++; $display("FAIL R5 model: activate while row %0d open act=1 exp=0", m_row); end
        m_row = bank_addr[RW-1:0];
        for (int c = 0; c < (1<<CW); c++) lat[c] = arr[m_row][c];
        m_open = 1'b1;
      end
      if (bank_rd) begin
        if (!m_open) begin model_errs++; $display("FAIL R3 model: read with no open row act=0 exp=1"); end
        m_rdata = lat[bank_addr[CW-1:0]];
      end
      if (bank_wr) begin
        if (!m_open) begin model_errs++; $display("FAIL R3 model: write with no open row act=0 exp=1"); end
        lat[bank_addr[CW-1:0]] = bank_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails + model_errs);
  endtask

  task automatic check_idle(input string req);
    check({bank_act, bank_rd, bank_wr, bank_pre} == 4'b0, req, "strobes",
          {bank_act, bank_rd, bank_wr, bank_pre}, 0);
    check(req_ready == 1'b1, req, "ready", req_ready, 1);
    check(rsp_valid == 1'b0, req, "rsp_valid", rsp_valid, 0);
    check(bank_addr == '0, req, "addr", bank_addr, 0);
  endtask

  task automatic run_req(input logic [1:0] kind, input logic w, input logic [RW-1:0] row,
                         input logic [CW-1:0] col, input logic [DW-1:0] data);
    int pre_at, act_at, col_at, end_at;
    string tag;
    pre_at = -1; act_at = -1;
    case (kind)
      2'd0: begin col_at = 0; tag = "R4"; end
      2'd1: begin act_at = 0; col_at = TA; tag = "R3"; end
      default: begin pre_at = 0; act_at = TP; col_at = TP + TA; tag = "R5"; end
    endcase
    end_at = col_at + TC;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_row = row; req_col = col; req_wdata = w ? data : ~data;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n <= end_at; n++) begin
      logic [3:0] exp_s;
      exp_s = {n == act_at, n == col_at && !w, n == col_at && w, n == pre_at};
      check({bank_act, bank_rd, bank_wr, bank_pre} == exp_s, (n == col_at && n > 0) ? "R8" : tag,
            "strobes {act,rd,wr,pre}", {bank_act, bank_rd, bank_wr, bank_pre}, exp_s);
      if (n == act_at)
        check(bank_addr == AW'(row), "R10", "row on bus", bank_addr, row);
      else if (n == col_at)
        check(bank_addr == AW'(col), "R10", "column on bus", bank_addr, col);
      else
        check(bank_addr == '0, "R10", "idle bus", bank_addr, 0);
      if (n == col_at && w)
        check(bank_wdata == data, "R7", "write data", bank_wdata, data);
      check(req_ready == (n == end_at), "R2", "ready", req_ready, n == end_at);
      check(rsp_valid == (n == end_at && !w), w ? "R7" : "R6", "rsp_valid", rsp_valid, n == end_at && !w);
      if (n == end_at && !w)
        check(rsp_data == data, "R6", "read data", rsp_data, data);
      if (n < end_at) @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish act=0 exp=1");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    for (int i = 0; i < NV; i++)
      run_req(VEC[i][17:16], VEC[i][15], VEC[i][14:11], VEC[i][10:8], VEC[i][7:0]);
    // reset with row 9 open: next request must activate without precharge (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    run_req(2'd1, 1'b0, 4'd9, 3'd2, 8'h77);
    run_req(2'd0, 1'b0, 4'd9, 3'd3, 8'h4B);
    // write to the highest row and column, reopen, read back (R7)
    run_req(2'd2, 1'b1, 4'd15, 3'd7, 8'hC3);
    run_req(2'd2, 1'b0, 4'd0, 3'd1, 8'h01);
    run_req(2'd2, 1'b0, 4'd15, 3'd7, 8'hC3);
    @(negedge clk);
    check_idle("R9");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule